// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Table Prescaler

This peripheral produces two independent pulse-width modulated outputs from one source clock. Software programs it through a small word-addressed register port: one shared control word holds a ten-bit field group for each channel, and each channel has its own timing word that packs the period length and the active-tick count. Every channel first slows the source clock through a prescaler whose divide ratios come from a fixed, non-uniform lookup. It then steps a 16-bit tick counter around the programmed period, and drives its pin to a chosen active level for the first part of each period.

New timing words do not disturb a running waveform. A write is held in a staging register and taken over only when the current period ends, and a status bit in the control word shows that a write is still waiting. A per-channel pass-through setting bypasses all of this and puts the undivided source clock on the pin.

Top module: `pwmc_top`

## Requirements
- R1: After reset every register reads 0, no write is pending, and both outputs sit at 1, which is the inactive level while the active-level bit is 0.
- R2: Byte address 0x0 is the control word, and 0x4 + 4*n is channel n's timing word. Channel n's control fields sit at bits 15*n+9 .. 15*n and read back as written; bits 28+n are read-only pending flags, and all other control bits read 0. A timing word reads back the value last written.
- R3: Inside a channel's control field, bit 4 enables it and bit 6 opens its clock gate. The channel runs only while both are 1. While it is not running, its output holds the inactive level and its counters clear, so re-enabling starts a fresh period with the counter at 0.
- R4: Timing word bits 31:16 hold the period length minus one, in ticks, and bits 15:0 hold the duty D. During each period the tick counter goes from 0 up to that length minus one, and the output is active while the counter is below D. D = 0 never drives the active level, and D at or above the period length always drives it.
- R5: Control bit 5 selects the active level: 1 makes the active level high, 0 makes it low. The inactive level is always the opposite.
- R6: Control bits 3:0 select the prescale ratio. Codes 0 to 4 give 120, 180, 240, 360 and 480; codes 8 to 12 give 12000, 24000, 36000, 48000 and 72000; code 15 gives 1, one tick per source cycle.
- R7: Codes 5, 6, 7, 13 and 14 are reserved. Under a reserved code no ticks are produced, so the counter and the output freeze. Selecting a valid code resumes counting.
- R8: A timing-word write is staged and takes effect at the next period boundary of a running channel, or in the next cycle if the channel is stopped. Its pending flag at control bit 28+n reads 1 from the cycle after the write until it takes effect.
- R9: While control bit 9 (pass-through) is 1, the channel output equals the source clock, whatever the enable, gate and other fields hold.
- R10: The two channels are independent: the settings of one channel never change the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; clocks the registers and drives the pass-through path |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr; combinational |
| pwm_o | output | NCH | One modulated output per channel |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit tick counters and a four-bit byte address. These defaults make the shared-control layout, both pending flags and cross-channel isolation observable. With code 15 a single-tick period lasts one clock, so duty, polarity, restart phase and the staging boundary can be checked exactly over windows of whole periods. The 120, 360, 480 and 12000 ratios are each measured over two full output periods, which keeps the longest run inside the cycle budget.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int FLD_STRIDE = 15;  // control field spacing per channel
  localparam int FLD_W      = 10;  // width of one channel's control field
  localparam int RDY_BASE   = 28;  // first pending-flag bit
  localparam int REG_W      = 32;
  localparam int DIV_W      = 17;  // holds the largest ratio, 72000

  // Packed MSB first so the struct lines up with control bits 9..0.
  typedef struct packed {
    logic       thru;    // bit 9: source clock straight to the pin
    logic       pls;     // bit 8: stored only
    logic       mde;     // bit 7: stored only
    logic       gate;    // bit 6
    logic       act;     // bit 5: 1 = active high
    logic       en;      // bit 4
    logic [3:0] pre;     // bits 3:0
  } chan_ctl_t;

  // Prescale ratio for a code; 0 marks a reserved code.
  function automatic logic [DIV_W-1:0] pre_div(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    unique case (code)
      4'd0:    d = DIV_W'(120);
      4'd1:    d = DIV_W'(180);
      4'd2:    d = DIV_W'(240);
      4'd3:    d = DIV_W'(360);
      4'd4:    d = DIV_W'(480);
      4'd8:    d = DIV_W'(12000);
      4'd9:    d = DIV_W'(24000);
      4'd10:   d = DIV_W'(36000);
      4'd11:   d = DIV_W'(48000);
      4'd12:   d = DIV_W'(72000);
      4'd15:   d = DIV_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwmc_tick.sv
module pwmc_tick
  import pwmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic             stall;

  assign div   = pre_div(code_i);
  assign stall = (div == '0);

  always_comb begin
    pcnt_d = pcnt_q;
    tick_o = 1'b0;
    if (!run_i) begin
      pcnt_d = '0;
    end else if (!stall) begin
      // >= so a switch to a smaller ratio never overruns the wrap point
      if (pcnt_q >= div - DIV_W'(1)) begin
        pcnt_d = '0;
        tick_o = 1'b1;
      end else begin
        pcnt_d = pcnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // Ratio 1 must tick on every running cycle.
  assert_div1_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && code_i == 4'd15) |-> tick_o);

endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_ctl_t         ctl_i,
  input  logic              wr_i,
  input  logic [2*CNT_W-1:0] wdata_i,
  output logic              pend_o,
  output logic [2*CNT_W-1:0] staged_o,
  output logic              pwm_o
);

  localparam int TW = 2 * CNT_W;

  logic             run, tick, boundary, load;
  logic [CNT_W-1:0] cnt_q, cnt_d, prd_q, prd_d, dty_q, dty_d;
  logic [TW-1:0]    stg_q, stg_d;
  logic             pend_q, pend_d, pwm_q, pwm_d;
  logic             unused_ctl;

  assign unused_ctl = ctl_i.mde ^ ctl_i.pls;
  assign run        = ctl_i.en & ctl_i.gate & ~ctl_i.thru;

  pwmc_tick u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .code_i (ctl_i.pre),
    .tick_o (tick)
  );

  always_comb begin
    stg_d    = wr_i ? wdata_i : stg_q;
    boundary = !run || (tick && cnt_q == prd_q);
    load     = pend_q && boundary;
    prd_d    = load ? stg_q[TW-1:CNT_W] : prd_q;
    dty_d    = load ? stg_q[CNT_W-1:0]  : dty_q;
    pend_d   = wr_i | (pend_q & ~load);
    if (!run)                cnt_d = '0;
    else if (!tick)          cnt_d = cnt_q;
    else if (cnt_q == prd_q) cnt_d = '0;
    else                     cnt_d = cnt_q + CNT_W'(1);
    pwm_d = (run && cnt_q < dty_q) ? ctl_i.act : ~ctl_i.act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prd_q  <= '0;
      dty_q  <= '0;
      stg_q  <= '0;
      pend_q <= 1'b0;
      pwm_q  <= 1'b1;  // inactive level for the reset polarity
    end else begin
      cnt_q  <= cnt_d;
      prd_q  <= prd_d;
      dty_q  <= dty_d;
      stg_q  <= stg_d;
      pend_q <= pend_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pend_o   = pend_q;
  assign staged_o = stg_q;
  assign pwm_o    = ctl_i.thru ? clk : pwm_q;

  assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_q);

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pwm_q == !$past(ctl_i.act));

  assert_take_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> cnt_q == '0);

  assert_reserved_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_div(ctl_i.pre) == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NCH    = 2,   // the control layout fits at most two channels
  parameter int CNT_W  = 16,  // 2*CNT_W must not exceed 32
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int TW    = 2 * CNT_W;

  logic [1:0]       rsync_q;
  logic             srst_n;
  logic [IDX_W-1:0] widx;
  logic             ctl_we;
  logic [NCH-1:0]   prd_we, pend;
  logic [TW-1:0]    staged [NCH];
  chan_ctl_t        ctl_q  [NCH];
  chan_ctl_t        ctl_d  [NCH];
  logic             unused_addr;

  assign unused_addr = ^bus_addr[1:0];

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  assign widx   = bus_addr[ADDR_W-1:2];
  assign ctl_we = bus_we && (widx == '0);

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      prd_we[n] = bus_we && (widx == IDX_W'(n + 1));
      ctl_d[n]  = ctl_we ? chan_ctl_t'(bus_wdata[n*FLD_STRIDE +: FLD_W]) : ctl_q[n];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int n = 0; n < NCH; n++) ctl_q[n] <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) ctl_q[n] <= ctl_d[n];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (srst_n),
      .ctl_i    (ctl_q[g]),
      .wr_i     (prd_we[g]),
      .wdata_i  (bus_wdata[TW-1:0]),
      .pend_o   (pend[g]),
      .staged_o (staged[g]),
      .pwm_o    (pwm_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (widx == '0) begin
      for (int n = 0; n < NCH; n++) begin
        bus_rdata[n*FLD_STRIDE +: FLD_W] = ctl_q[n];
        bus_rdata[RDY_BASE + n]          = pend[n];
      end
    end else begin
      for (int n = 0; n < NCH; n++)
        if (widx == IDX_W'(n + 1)) bus_rdata[TW-1:0] = staged[n];
    end
  end

  // A write lands in at most one register.
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({ctl_we, prd_we}));

endmodule

// File: tb/test_pwmc_top.sv
module test_pwmc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_o;

  always #10 clk = ~clk;  // 50 MHz

  pwmc_top i_pwmc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_o     (pwm_o)
  );

  typedef struct {
    string       req;
    logic [31:0] val;
  } item_t;

  item_t exp_q[$];
  item_t act_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Monitor: pairs each expected item with the observed one.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_vec++;
      if (e.val !== a.val) begin
        n_bad++;
        $display("FAIL %s: got 0x%0h, expected 0x%0h", e.req, a.val, e.val);
      end
    end
  end

  task automatic expect_val(input string req, input logic [31:0] exp, input logic [31:0] act);
    exp_q.push_back('{req, exp});
    act_q.push_back('{req, act});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Count active-high samples over n cycles, one sample per falling edge.
  task automatic measure(input int ch, input int n, output logic [31:0] cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) cnt++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    int          miss;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(4'h0, v); expect_val("R1 ctrl", 32'h0, v);
    rd(4'h4, v); expect_val("R1 ch0 timing", 32'h0, v);
    expect_val("R1 outputs", 32'h3, {30'b0, pwm_o});

    // R2: field readback, reserved bits zero, ready bits read-only
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); expect_val("R2 ctrl readback", 32'h01FF_83FF, v);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1234_5678);
    rd(4'h4, v); expect_val("R2 timing readback", 32'h1234_5678, v);

    // R8: staged write waits for the period boundary
    wr(4'h4, {16'd499, 16'd500});        // stopped: taken at once
    wr(4'h0, 32'h0000_007F);             // code 15, en, act high, gate
    idle(10);
    wr(4'h4, {16'd9, 16'd0});
    rd(4'h0, v); expect_val("R8 pending set", 32'h1, {31'b0, v[28]});
    measure(0, 100, v); expect_val("R8 old settings kept", 32'd100, v);
    idle(450);
    rd(4'h0, v); expect_val("R8 pending cleared", 32'h0, {31'b0, v[28]});
    measure(0, 100, v); expect_val("R8 new duty 0", 32'd0, v);

    // R3: enable and gate both needed
    wr(4'h4, {16'd9, 16'd20});
    idle(20);
    wr(4'h0, 32'h0000_003F);             // gate closed
    idle(3);
    measure(0, 50, v); expect_val("R3 gate off", 32'd0, v);
    wr(4'h0, 32'h0000_006F);             // enable off
    idle(3);
    measure(0, 50, v); expect_val("R3 enable off", 32'd0, v);
    wr(4'h4, {16'd9, 16'd3});
    idle(5);
    wr(4'h0, 32'h0000_007F);
    pat = '0;
    for (int i = 0; i < 10; i++) begin
      pat[i] = pwm_o[0];
      @(negedge clk);
    end
    expect_val("R3 restart phase", 32'h0000_000E, pat);

    // R4: duty against period
    measure(0, 100, v); expect_val("R4 duty 3 of 10", 32'd30, v);
    wr(4'h4, {16'd9, 16'd9});
    idle(15);
    measure(0, 100, v); expect_val("R4 duty 9 of 10", 32'd90, v);
    wr(4'h4, {16'd9, 16'd10});
    idle(15);
    measure(0, 100, v); expect_val("R4 duty equals period", 32'd100, v);
    wr(4'h4, {16'd9, 16'd3});
    idle(15);

    // R5: active-low polarity
    wr(4'h0, 32'h0000_005F);
    idle(3);
    measure(0, 100, v); expect_val("R5 active low", 32'd70, v);

    // R7: reserved code freezes, valid code resumes
    wr(4'h0, 32'h0000_0075);
    idle(3);
    measure(0, 50, v);
    expect_val("R7 frozen output", 32'h1, {31'b0, (v == 0 || v == 50)});
    wr(4'h0, 32'h0000_007F);
    idle(3);
    measure(0, 100, v); expect_val("R7 resumed", 32'd30, v);

    // R6: prescale ratios, 2-tick period, 1 active tick
    wr(4'h0, 32'h0);
    wr(4'h4, {16'd1, 16'd1});
    wr(4'h0, 32'h0000_0070);             // code 0: 120
    idle(300);
    measure(0, 480, v); expect_val("R6 ratio 120", 32'd240, v);
    wr(4'h0, 32'h0000_0073);             // code 3: 360
    idle(800);
    measure(0, 1440, v); expect_val("R6 ratio 360", 32'd720, v);
    wr(4'h0, 32'h0000_0074);             // code 4: 480
    idle(1000);
    measure(0, 1920, v); expect_val("R6 ratio 480", 32'd960, v);
    wr(4'h0, 32'h0000_0078);             // code 8: 12000
    idle(24100);
    measure(0, 48000, v); expect_val("R6 ratio 12000", 32'd24000, v);

    // R10: two channels with different settings
    wr(4'h0, 32'h0);
    wr(4'h4, {16'd9, 16'd3});
    wr(4'h8, {16'd4, 16'd2});
    wr(4'h0, 32'h003F_807F);
    idle(20);
    measure(0, 100, v); expect_val("R10 ch0", 32'd30, v);
    measure(1, 100, v); expect_val("R10 ch1", 32'd40, v);

    // R9: pass-through on ch1 with enable off; ch0 unaffected
    wr(4'h0, 32'h0100_007F);
    idle(3);
    miss = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #5 if (pwm_o[1] !== 1'b1) miss++;
      @(negedge clk); #5 if (pwm_o[1] !== 1'b0) miss++;
    end
    expect_val("R9 follows clock", 32'd0, miss);
    measure(0, 100, v); expect_val("R10 ch0 beside pass-through", 32'd30, v);

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule